// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synchronous static memory that accepts a new command on every clock cycle. The commands can be reads, writes or burst continuations, and they can be mixed in any order. Address, byte enables and control are registered on the rising clock edge. Write data does not travel with its address: it arrives on a later active edge, one edge later in flow-through mode and two edges later in pipelined mode. Because of this offset, a read and a write can follow each other with no idle cycles on the data bus.

A static mode input picks the read latency. In pipelined mode, read data passes through an output register. In flow-through mode, read data comes straight from the array. A two-bit burst counter lets a single start address serve four consecutive beats, in either linear or interleaved order. A pipelined read of an address whose write data has not yet reached the array gets that data, merged per lane, through a bypass path. The array is a plain behavioural register array built from 9-bit byte lanes.

Top module: `zero_ta_sram`

## Requirements
- R1: A command is accepted only when `ce0_ni`=0, `ce1_ni`=0 and `ce2_i`=1 at the same active edge. Any other combination causes no array write, no output drive and no burst state change.
- R2: In pipelined mode (`pipe_i`=1), a read accepted at active edge E drives its data on `rdata_o`, with `rdrive_o`=1, from active edge E+1 until active edge E+2.
- R3: In flow-through mode (`pipe_i`=0), a read accepted at active edge E drives its data from just after edge E until edge E+1.
- R4: The write data for a write accepted at active edge E is taken from `wdata_i` at edge E+2 in pipelined mode and at edge E+1 in flow-through mode.
- R5: Reads, writes and bursts may follow one another on consecutive cycles, with no idle cycle between them, and every read returns the most recently written data.
- R6: Byte enable `be_ni[k]`, which is active low, controls lane k, bits [9k+8:9k]. Lanes whose enable is high keep their old contents.
- R7: In pipelined mode, a read issued on the cycle right after a write to the same address returns the write data on the enabled lanes and the old array contents on the other lanes.
- R8: While `cke_ni`=1 the edge is ignored. No command is accepted, no write data is taken, and the pipeline and outputs hold their values.
- R9: A selected command with `adv_i`=1 repeats the read or write type of the burst's start command. With `ilv_i`=0, the address LSBs for step n are (start LSBs + n) mod 4, and the upper address bits are unchanged.
- R10: With `ilv_i`=1, the address LSBs for burst step n are the start LSBs XOR n.
- R11: `oe_ni`=1 forces `rdrive_o`=0 and `rdata_o`=0 at once, without waiting for a clock edge. Whenever `rdrive_o`=0, `rdata_o` reads zero.
- R12: While `rst_ni`=0, and immediately after reset, `rdrive_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low |
| ce0_ni | input | 1 | Chip enable, active low |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| we_ni | input | 1 | Write command, active low |
| adv_i | input | 1 | Burst continue |
| addr_i | input | ADDR_W | Word address; the two LSBs preset the burst counter |
| be_ni | input | LANES | Byte-lane write enables, active low |
| wdata_i | input | 9*LANES | Late write data |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| pipe_i | input | 1 | 1 = pipelined mode, 0 = flow-through mode (static) |
| ilv_i | input | 1 | Burst order: 0 = linear, 1 = interleaved |
| rdata_o | output | 9*LANES | Read data, zero when not driven |
| rdrive_o | output | 1 | Read data is being driven |

## Verification
Each mode is first exercised with runs of back-to-back writes followed by runs of back-to-back reads. A fixed junk pattern sits on the write data bus on every edge that should not be sampled, so a misaligned late-write capture shows up as corrupt readback. Alternating write/read patterns to the same and to different addresses then tell the bypass path apart from plain array reads, and partial-lane writes show whether the merge follows the byte enables. Burst reads from a start address with LSBs 01 give different orders for linear and interleaved stepping. Stalled cycles that carry a selected write, writes with each chip-enable combination deselected, and an output-enable toggle while data is driven cover the cases where nothing should happen.

// File: rtl/zta_pkg.sv
`timescale 1ns/1ps
package zta_pkg;
  localparam int unsigned LANE_W = 9;

  typedef enum logic {
    ORD_LIN = 1'b0,
    ORD_ILV = 1'b1
  } ord_e;

  typedef struct packed {
    logic vld;
    logic wr;
  } op_t;

  function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input ord_e       ord);
    return (ord == ORD_ILV) ? (start ^ step) : (start + step);
  endfunction
endpackage

// File: rtl/zta_burst.sv
`timescale 1ns/1ps
module zta_burst
  import zta_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          sel_i,
  input  logic          adv_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  ord_e          ord_i,
  output op_t           op_o,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base_q;
  logic [1:0]    step_q, nxt_step;
  logic          wr_q;

  always_comb begin
    nxt_step = step_q + 2'd1;
    op_o     = '0;
    addr_o   = addr_i;
    if (sel_i) begin
      op_o.vld = 1'b1;
      if (adv_i) begin
        op_o.wr = wr_q;
        addr_o  = {base_q[AW-1:2], burst_lsb(base_q[1:0], nxt_step, ord_i)};
      end else begin
        op_o.wr = wr_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      step_q <= '0;
      wr_q   <= 1'b0;
    end else if (en_i && sel_i) begin
      if (adv_i) begin
        step_q <= nxt_step;
      end else begin
        base_q <= addr_i;
        step_q <= '0;
        wr_q   <= wr_i;
      end
    end
  end

  // R9: consecutive linear advances step the LSBs by one, upper bits fixed
  a_r9_linear_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sel_i && adv_i && ord_i == ORD_LIN) ##1 (en_i && sel_i && adv_i && ord_i == ORD_LIN)
    |-> (addr_o[1:0] == $past(addr_o[1:0]) + 2'd1) && (addr_o[AW-1:2] == $past(addr_o[AW-1:2])));
endmodule

// File: rtl/zta_cmd_pipe.sv
`timescale 1ns/1ps
module zta_cmd_pipe
  import zta_pkg::*;
#(
  parameter int unsigned AW    = 6,
  parameter int unsigned NB    = 2,
  parameter int unsigned DEPTH = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           en_i,
  input  op_t                            op_i,
  input  logic [AW-1:0]                  addr_i,
  input  logic [NB-1:0]                  be_i,
  output op_t  [DEPTH-1:0]               op_o,
  output logic [DEPTH-1:0][AW-1:0]       addr_o,
  output logic [DEPTH-1:0][NB-1:0]       be_o
);
  op_t  [DEPTH-1:0]         op_q;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][NB-1:0] be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= '0;
      addr_q <= '0;
      be_q   <= '0;
    end else if (en_i) begin
      op_q[0]   <= op_i;
      addr_q[0] <= addr_i;
      be_q[0]   <= be_i;
      for (int s = 1; s < DEPTH; s++) begin
        op_q[s]   <= op_q[s-1];
        addr_q[s] <= addr_q[s-1];
        be_q[s]   <= be_q[s-1];
      end
    end
  end

  assign op_o   = op_q;
  assign addr_o = addr_q;
  assign be_o   = be_q;
endmodule

// File: rtl/zta_array.sv
`timescale 1ns/1ps
module zta_array
  import zta_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned NB = 2
) (
  input  logic                 clk_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        waddr_i,
  input  logic [NB-1:0]        wbe_i,
  input  logic [NB*LANE_W-1:0] wdata_i,
  input  logic [AW-1:0]        raddr_i,
  output logic [NB*LANE_W-1:0] rdata_o
);
  localparam int unsigned WORDS = 1 << AW;
  localparam int unsigned DW    = NB * LANE_W;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int k = 0; k < NB; k++) begin
        if (wbe_i[k]) mem[waddr_i][k*LANE_W +: LANE_W] <= wdata_i[k*LANE_W +: LANE_W];
      end
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/zero_ta_sram.sv
`timescale 1ns/1ps
module zero_ta_sram
  import zta_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cke_ni,
  input  logic                    ce0_ni,
  input  logic                    ce1_ni,
  input  logic                    ce2_i,
  input  logic                    we_ni,
  input  logic                    adv_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        be_ni,
  input  logic [LANES*9-1:0]      wdata_i,
  input  logic                    oe_ni,
  input  logic                    pipe_i,
  input  logic                    ilv_i,
  output logic [LANES*9-1:0]      rdata_o,
  output logic                    rdrive_o
);
  localparam int unsigned DW     = LANES * LANE_W;
  localparam int unsigned STAGES = 2;

  logic en, sel;
  assign en  = ~cke_ni;
  assign sel = ~ce0_ni & ~ce1_ni & ce2_i;

  op_t                          cmd_op;
  logic [ADDR_W-1:0]            cmd_addr;
  op_t  [STAGES-1:0]            st_op;
  logic [STAGES-1:0][ADDR_W-1:0] st_addr;
  logic [STAGES-1:0][LANES-1:0] st_be;

  zta_burst #(.AW(ADDR_W)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .sel_i  (sel),
    .adv_i  (adv_i),
    .wr_i   (~we_ni),
    .addr_i (addr_i),
    .ord_i  (ord_e'(ilv_i)),
    .op_o   (cmd_op),
    .addr_o (cmd_addr)
  );

  zta_cmd_pipe #(.AW(ADDR_W), .NB(LANES), .DEPTH(STAGES)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .op_i   (cmd_op),
    .addr_i (cmd_addr),
    .be_i   (~be_ni),
    .op_o   (st_op),
    .addr_o (st_addr),
    .be_o   (st_be)
  );

  op_t               a_op, b_op;
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic [LANES-1:0]  a_be, b_be;
  assign a_op   = st_op[0];
  assign b_op   = st_op[1];
  assign a_addr = st_addr[0];
  assign b_addr = st_addr[1];
  assign a_be   = st_be[0];
  assign b_be   = st_be[1];

  // late write: commit from stage B (pipelined) or stage A (flow-through)
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [LANES-1:0]  wr_be;
  always_comb begin
    if (pipe_i) begin
      wr_en   = en & b_op.vld & b_op.wr;
      wr_addr = b_addr;
      wr_be   = b_be;
    end else begin
      wr_en   = en & a_op.vld & a_op.wr;
      wr_addr = a_addr;
      wr_be   = a_be;
    end
  end

  logic [DW-1:0] mem_rd;
  zta_array #(.AW(ADDR_W), .NB(LANES)) u_array (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wbe_i   (wr_be),
    .wdata_i (wdata_i),
    .raddr_i (a_addr),
    .rdata_o (mem_rd)
  );

  // read-after-write bypass: write in B commits on the edge that loads the output register
  logic          byp_hit;
  logic [DW-1:0] byp_dat;
  assign byp_hit = b_op.vld & b_op.wr & (b_addr == a_addr);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign byp_dat[k*LANE_W +: LANE_W] = (byp_hit && b_be[k]) ? wdata_i[k*LANE_W +: LANE_W]
                                                              : mem_rd[k*LANE_W +: LANE_W];
  end

  logic          pq_vld;
  logic [DW-1:0] pq_dat;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pq_vld <= 1'b0;
      pq_dat <= '0;
    end else if (en) begin
      pq_vld <= a_op.vld & ~a_op.wr;
      pq_dat <= byp_dat;
    end
  end

  logic          rd_vld;
  logic [DW-1:0] rd_dat;
  assign rd_vld   = pipe_i ? pq_vld : (a_op.vld & ~a_op.wr);
  assign rd_dat   = pipe_i ? pq_dat : mem_rd;
  assign rdrive_o = rd_vld & ~oe_ni;
  assign rdata_o  = rdrive_o ? rd_dat : '0;

  // R1: unselected edge loads no command into stage A
  a_r1_desel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && !sel |=> !a_op.vld);
  // R2: pipelined read in stage A yields a valid output register next edge
  a_r2_pipe_lat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_i && en && a_op.vld && !a_op.wr |=> pq_vld);
  // R7: full-lane write just ahead of a same-address read is forwarded
  a_r7_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_i && en && a_op.vld && !a_op.wr && b_op.vld && b_op.wr && (a_addr == b_addr) && (&b_be)
    |=> pq_dat == $past(wdata_i));
  // R8: stalled edge leaves the command stage untouched
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> $stable(a_op) && $stable(a_addr));
  // R11: disabled output reads zero
  a_r11_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> rdata_o == '0);
endmodule

// File: tb/zero_ta_sram_bench.sv
`timescale 1ns/1ps
module zero_ta_sram_bench;
  localparam int AW = 6;
  localparam int NL = 2;
  localparam int DW = NL * 9;
  localparam logic [DW-1:0] JUNK = 18'h15a5a;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cke_ni, ce0_ni, ce1_ni, ce2_i, we_ni, adv_i, oe_ni, pipe_i, ilv_i;
  logic [AW-1:0] addr_i;
  logic [NL-1:0] be_ni;
  logic [DW-1:0] wdata_i, rdata_o;
  logic rdrive_o;

  zero_ta_sram #(.ADDR_W(AW), .LANES(NL)) u_zero_ta_sram (
    .clk_i(clk), .rst_ni(rst_ni), .cke_ni(cke_ni), .ce0_ni(ce0_ni), .ce1_ni(ce1_ni),
    .ce2_i(ce2_i), .we_ni(we_ni), .adv_i(adv_i), .addr_i(addr_i), .be_ni(be_ni),
    .wdata_i(wdata_i), .oe_ni(oe_ni), .pipe_i(pipe_i), .ilv_i(ilv_i),
    .rdata_o(rdata_o), .rdrive_o(rdrive_o)
  );

  always #2 clk = ~clk;

  int edge_cnt = 0;
  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  typedef struct {
    int            due;
    logic [DW-1:0] dat;
    string         tag;
  } exp_t;

  exp_t          sb_q[$];
  logic [DW-1:0] wd_map[int];
  logic [DW-1:0] ref_mem[64];
  bit            idle_chk = 1'b0;
  bit            sb_en = 1'b1;
  int            n_chk = 0;
  int            n_bad = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_step = '0;
  bit            m_wr = 1'b0;

  function automatic logic [DW-1:0] mkd(input int i);
    return DW'(i * 4099 + 17);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  // monitor: compare scoreboard heads, otherwise expect a quiet bus
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (sb_q.size() > 0 && sb_q[0].due == edge_cnt) begin
      e = sb_q.pop_front();
      chk(rdrive_o === 1'b1 && rdata_o === e.dat, e.tag, rdata_o, e.dat);
    end else if (idle_chk) begin
      chk(rdrive_o === 1'b0, "R1/R2 no read due, bus must be quiet", DW'(rdrive_o), '0);
    end
  end

  // ce_pat = {ce2, ce1_n, ce0_n}; 3'b100 selects
  task automatic issue(input logic [2:0] ce_pat, input bit wr, input bit adv,
                       input logic [AW-1:0] a, input logic [NL-1:0] ben,
                       input logic [DW-1:0] d, input string tag);
    int            e;
    logic [AW-1:0] eff;
    bit            w;
    @(negedge clk);
    e      = edge_cnt + 1;
    cke_ni = 1'b0;
    ce0_ni = ce_pat[0];
    ce1_ni = ce_pat[1];
    ce2_i  = ce_pat[2];
    we_ni  = ~wr;
    adv_i  = adv;
    addr_i = a;
    be_ni  = ben;
    if (ce_pat == 3'b100) begin
      if (adv) begin
        m_step = m_step + 2'd1;
        eff = {m_base[AW-1:2], ilv_i ? (m_base[1:0] ^ m_step) : (m_base[1:0] + m_step)};
        w   = m_wr;
      end else begin
        m_base = a; m_step = '0; m_wr = wr;
        eff = a;
        w   = wr;
      end
      if (w) begin
        wd_map[e + (pipe_i ? 2 : 1)] = d;
        for (int k = 0; k < NL; k++)
          if (!ben[k]) ref_mem[eff][k*9 +: 9] = d[k*9 +: 9];
      end else if (sb_en) begin
        sb_q.push_back('{due: e + (pipe_i ? 1 : 0), dat: ref_mem[eff], tag: tag});
      end
    end
    if (wd_map.exists(e)) begin
      wdata_i = wd_map[e];
      wd_map.delete(e);
    end else begin
      wdata_i = JUNK;
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] ben, input logic [DW-1:0] d, input string tag);
    issue(3'b100, 1'b1, 1'b0, a, ben, d, tag);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string tag);
    issue(3'b100, 1'b0, 1'b0, a, '1, '0, tag);
  endtask
  task automatic adv(input logic [DW-1:0] d, input string tag);
    issue(3'b100, 1'b0, 1'b1, '0, '0, d, tag);
  endtask
  task automatic nop();
    issue(3'b011, 1'b0, 1'b0, '0, '1, '0, "nop");
  endtask
  task automatic drain();
    repeat (3) nop();
    while (sb_q.size() != 0) @(posedge clk);
  endtask

  initial begin
    #(4 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R5 act=%h exp=%h", sb_q.size(), 0);
    summary();
    $finish;
  end

  initial begin
    cke_ni = 1'b0; ce0_ni = 1'b1; ce1_ni = 1'b1; ce2_i = 1'b0; we_ni = 1'b1; adv_i = 1'b0;
    addr_i = '0; be_ni = '1; wdata_i = JUNK; oe_ni = 1'b0; pipe_i = 1'b1; ilv_i = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk(rdrive_o === 1'b0 && rdata_o === '0, "R12 during reset", rdata_o, '0);
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk);
    #1 chk(rdrive_o === 1'b0, "R12 after reset", DW'(rdrive_o), '0);
    idle_chk = 1'b1;

    // pipelined: back-to-back writes then reads
    for (int i = 0; i < 8; i++) wr(AW'(i), 2'b00, mkd(i), "R4 pipe write");
    for (int i = 0; i < 8; i++) rd(AW'(i), "R2 R4 pipe read");
    // mixed traffic, no idle cycles
    wr(30, 2'b00, mkd(30), "R5");
    rd(0, "R5 pipe mixed");
    wr(31, 2'b00, mkd(31), "R5");
    rd(30, "R5 pipe mixed");
    rd(31, "R5 pipe mixed");
    wr(0, 2'b00, mkd(40), "R5");
    rd(0, "R7 pipe bypass full");
    wr(32, 2'b00, mkd(41), "R7");
    rd(32, "R7 pipe bypass full");
    // partial lanes, with and without bypass
    wr(3, 2'b10, mkd(50), "R6");
    rd(3, "R6 R7 pipe bypass lane0 only");
    wr(4, 2'b01, mkd(51), "R6");
    nop();
    rd(4, "R6 pipe lane1 only");
    // deselected write attempts
    wr(5, 2'b00, mkd(5), "R1");
    issue(3'b101, 1'b1, 1'b0, 5, 2'b00, mkd(60), "R1");
    issue(3'b110, 1'b1, 1'b0, 5, 2'b00, mkd(61), "R1");
    issue(3'b000, 1'b1, 1'b0, 5, 2'b00, mkd(62), "R1");
    issue(3'b101, 1'b0, 1'b1, 5, 2'b00, mkd(63), "R1");
    nop();
    rd(5, "R1 deselected writes ignored");
    // burst from start LSBs 01
    wr(13, 2'b00, mkd(70), "R9");
    adv(mkd(71), "R9 burst write");
    adv(mkd(72), "R9 burst write");
    adv(mkd(73), "R9 burst write");
    rd(13, "R9 linear read");
    adv('0, "R9 linear step1");
    adv('0, "R9 linear step2");
    adv('0, "R9 linear step3");
    drain();
    ilv_i = 1'b1;
    rd(13, "R10 interleave read");
    adv('0, "R10 interleave step1");
    adv('0, "R10 interleave step2");
    adv('0, "R10 interleave step3");
    drain();
    ilv_i = 1'b0;

    // output enable and clock enable
    wr(20, 2'b00, mkd(80), "R11");
    wr(21, 2'b00, mkd(81), "R8");
    drain();
    idle_chk = 1'b0;
    sb_en = 1'b0;
    rd(20, "R11");
    nop();
    @(posedge clk);
    #1 chk(rdrive_o === 1'b1 && rdata_o === mkd(80), "R2 pipe read before oe", rdata_o, mkd(80));
    oe_ni = 1'b1;
    #0.25 chk(rdrive_o === 1'b0 && rdata_o === '0, "R11 oe high blanks bus", rdata_o, '0);
    oe_ni = 1'b0;
    #0.25 chk(rdrive_o === 1'b1 && rdata_o === mkd(80), "R11 oe low restores", rdata_o, mkd(80));
    @(negedge clk);
    cke_ni = 1'b1; ce0_ni = 1'b0; ce1_ni = 1'b0; ce2_i = 1'b1; we_ni = 1'b0;
    addr_i = 21; be_ni = '0; wdata_i = mkd(99);
    repeat (2) begin
      @(posedge clk);
      #1 chk(rdrive_o === 1'b1 && rdata_o === mkd(80), "R8 stall holds output", rdata_o, mkd(80));
    end
    @(negedge clk);
    cke_ni = 1'b0; ce0_ni = 1'b1; ce1_ni = 1'b1; ce2_i = 1'b0; we_ni = 1'b1; wdata_i = JUNK;
    drain();
    sb_en = 1'b1;
    idle_chk = 1'b1;
    rd(21, "R8 stalled write ignored");
    drain();

    // flow-through
    pipe_i = 1'b0;
    for (int i = 40; i < 44; i++) wr(AW'(i), 2'b00, mkd(i), "R4 flow write");
    for (int i = 40; i < 44; i++) rd(AW'(i), "R3 R4 flow read");
    wr(44, 2'b00, mkd(44), "R5");
    rd(44, "R5 flow read after write");
    rd(40, "R5 flow mixed");
    wr(40, 2'b01, mkd(45), "R6");
    rd(40, "R6 flow lane1 only");
    wr(41, 2'b10, mkd(46), "R6");
    wr(42, 2'b00, mkd(47), "R5");
    rd(41, "R6 flow lane0 only");
    ilv_i = 1'b1;
    wr(49, 2'b00, mkd(90), "R10");
    adv(mkd(91), "R10 flow interleave write");
    adv(mkd(92), "R10 flow interleave write");
    adv(mkd(93), "R10 flow interleave write");
    drain();
    ilv_i = 1'b0;
    rd(49, "R9 flow linear read");
    adv('0, "R9 R10 flow linear step1");
    adv('0, "R9 R10 flow linear step2");
    adv('0, "R9 R10 flow linear step3");
    drain();

    idle_chk = 1'b0;
    summary();
    $finish;
  end
endmodule